// File: doc/BRIEF.md
# Serial Bus Control and Acknowledge Unit

This unit is the control and status logic of a two-wire, clocked serial bus port. Software writes one control byte through a simple register port. Three bits in that byte are self-clearing triggers. One forces the serial output latch high, which makes a bus-release signal. One forces the latch low, which makes a command signal. The third asks for a single acknowledge pulse. A fourth bit, which holds its value, turns on automatic acknowledge at the end of each 8-bit transfer.

The unit watches the serial clock and data lines through a synchronizer. A rising data edge while the clock stays high is taken as a bus-release condition. A falling data edge while the clock stays high is taken as a command condition. Each condition sets a sticky flag that software can read. The two flags are cleared by different sets of events. The shift register, the address comparator and the serial clock generator are outside the unit. They appear here only as the transfer-start strobe, the address-check strobe with its match input, and the serial clock input.

An acknowledge is the data line pulled low for one full serial clock period. It begins at a serial clock falling edge and ends at the falling edge that follows the next rising edge. All line outputs are open-drain: the unit only ever pulls the line low.

Top module: `sbus_ctl_top`

## Requirements
- R1: After reset, soLatch is 1, ackLow is 0, sdaOe is 0 and regRdData reads 8'h00.
- R2: A register write with bit 0 (release trigger) set drives soLatch to 1 from the next clock edge.
- R3: A register write with bit 1 (command trigger) set and bit 0 clear drives soLatch to 0. When bits 0 and 1 are both set, bit 0 wins. sdaOe is high whenever soLatch is 0 or ackLow is 1.
- R4: Read bit 4 (release flag) is set by a rising sdaIn while sclIn stays high. The flag is visible within 4 clocks of the edge.
- R5: The release flag is cleared by an xferStart pulse, by portEn low, or by an addrCheck pulse with addrHit low. An addrCheck pulse with addrHit high leaves it unchanged.
- R6: Read bit 5 (command flag) is set by a falling sdaIn while sclIn stays high. It is cleared by an xferStart pulse, by portEn low, or by detection of a release condition. A release condition therefore sets bit 4 and clears bit 5 at the same edge.
- R7: If bit 3 (auto-acknowledge enable) is 1 at any point up to and including the cycle in which the 8th sclIn rise after xferStart is detected, ackLow goes high after the next sclIn fall. It stays high until the sclIn fall that follows the next sclIn rise.
- R8: A write that changes bit 3 from 0 to 1 while no transfer is active starts one acknowledge at the next sclIn fall, lasting one serial clock period.
- R9: Writing bit 2 (acknowledge trigger) while no transfer is active starts one acknowledge at the next sclIn fall. The same write during an active transfer has no effect, so no acknowledge follows that transfer when bit 3 is 0.
- R10: Reads return bits 0, 1, 2, 6 and 7 as 0 and bit 3 as the last value written.
- R11: portEn low ends any acknowledge in progress (ackLow 0 from the next edge) and cancels a pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Port enable; low clears flags, transfer and acknowledge state |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| xferStart | input | 1 | One-cycle strobe marking the start of an 8-bit transfer |
| addrCheck | input | 1 | One-cycle strobe: a received address has been compared |
| addrHit | input | 1 | Result of that comparison, 1 when the address matched |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line, asynchronous |
| soLatch | output | 1 | Serial output latch value |
| ackLow | output | 1 | Acknowledge in progress (data line pulled low) |
| sdaOe | output | 1 | Open-drain pull-down enable for the data line |

## Verification
The close call is when a write of the auto-acknowledge enable lands in the same cycle as the 8th serial clock rise that ends the transfer. In that cycle the transfer is still counted as active, so the idle-arm path is off, and the stored enable is still 0. The bench sweeps the write across six offsets around the moment the 8th rise is detected. These offsets cover writes before, on and after the end cycle. In every case it expects exactly one acknowledge, starting at the 9th serial clock fall and released at the fall after it. A second coincidence is a release condition that sets the release flag while clearing the command flag in the same edge. The bench checks this by reading both flags after a command edge is followed by a release edge.

// File: rtl/sbus_ctl_pkg.sv
package sbus_ctl_pkg;

  // register bit positions
  localparam int BIT_REL_TRIG = 0;
  localparam int BIT_CMD_TRIG = 1;
  localparam int BIT_ACK_TRIG = 2;
  localparam int BIT_ACK_EN   = 3;
  localparam int BIT_REL_DET  = 4;
  localparam int BIT_CMD_DET  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic setSo;
    logic clrSo;
    logic armAck;
    logic startXfer;
    logic halt;
  } dpCmd_t;

  // events from datapath to control
  typedef struct packed {
    logic relSeen;
    logic cmdSeen;
    logic xferEndNow;
    logic xferActive;
  } dpEvt_t;

endpackage

// File: rtl/sbus_ctl_dp.sv
module sbus_ctl_dp
  import sbus_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int XFER_BITS   = 8
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   portEn,
  input  logic   sclIn,
  input  logic   sdaIn,
  input  dpCmd_t cmd,
  output dpEvt_t evt,
  output logic   soLatch,
  output logic   ackLow
);

  localparam int CNT_W = $clog2(XFER_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(XFER_BITS - 1);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;
  logic sclNow, sdaNow;
  logic sclRise, sclFall, sdaRise, sdaFall;

  // two-flop (or deeper) synchronizers on the line inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow  = sclPipe[SYNC_STAGES-1];
  assign sdaNow  = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclNow & ~sclPrev;
  assign sclFall = ~sclNow & sclPrev;
  assign sdaRise = sdaNow & ~sdaPrev;
  assign sdaFall = ~sdaNow & sdaPrev;

  // bit counter for the current transfer
  logic             active;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (cmd.halt) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (cmd.startXfer) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (active && sclRise) begin
      if (bitCnt == LAST_BIT) begin
        active <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  always_comb begin
    evt            = '0;
    evt.relSeen    = portEn & sdaRise & sclNow & sclPrev;
    evt.cmdSeen    = portEn & sdaFall & sclNow & sclPrev;
    evt.xferEndNow = active & sclRise & (bitCnt == LAST_BIT) & ~cmd.startXfer & ~cmd.halt;
    evt.xferActive = active;
  end

  // serial output latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          soLatch <= 1'b1;
    else if (cmd.setSo) soLatch <= 1'b1;
    else if (cmd.clrSo) soLatch <= 1'b0;
  end

  // acknowledge sequencer: pending -> low from a fall to the fall after next rise
  logic armed, sawRise, armNext;
  assign armNext = armed | cmd.armAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      ackLow  <= 1'b0;
      sawRise <= 1'b0;
    end else if (cmd.halt) begin
      armed   <= 1'b0;
      ackLow  <= 1'b0;
      sawRise <= 1'b0;
    end else if (sclFall) begin
      if (ackLow && sawRise) begin
        ackLow  <= 1'b0;
        sawRise <= 1'b0;
        armed   <= armNext;
      end else if (!ackLow && armNext) begin
        ackLow  <= 1'b1;
        sawRise <= 1'b0;
        armed   <= 1'b0;
      end else begin
        armed <= armNext;
      end
    end else begin
      armed <= armNext;
      if (ackLow && sclRise) sawRise <= 1'b1;
    end
  end

endmodule

// File: rtl/sbus_ctl_regs.sv
module sbus_ctl_regs
  import sbus_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              xferStart,
  input  logic              addrCheck,
  input  logic              addrHit,
  input  dpEvt_t            evt,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] regRdData
);

  logic ackEn, relDet, cmdDet;
  logic ackEnNext, idle, trigArm, enArm, autoArm;
  logic relClr, cmdClr;

  assign idle      = ~evt.xferActive;
  assign ackEnNext = regWr ? regWrData[BIT_ACK_EN] : ackEn;
  assign trigArm   = regWr & regWrData[BIT_ACK_TRIG] & idle;
  assign enArm     = regWr & regWrData[BIT_ACK_EN] & ~ackEn & idle;
  assign autoArm   = evt.xferEndNow & ackEnNext;

  always_comb begin
    cmd           = '0;
    cmd.setSo     = regWr & regWrData[BIT_REL_TRIG];
    cmd.clrSo     = regWr & regWrData[BIT_CMD_TRIG] & ~regWrData[BIT_REL_TRIG];
    cmd.armAck    = portEn & (trigArm | enArm | autoArm);
    cmd.startXfer = portEn & xferStart;
    cmd.halt      = ~portEn;
  end

  // clears take priority over a detection in the same cycle
  assign relClr = xferStart | ~portEn | (addrCheck & ~addrHit);
  assign cmdClr = xferStart | ~portEn | evt.relSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackEn  <= 1'b0;
      relDet <= 1'b0;
      cmdDet <= 1'b0;
    end else begin
      ackEn <= ackEnNext;
      if (relClr)           relDet <= 1'b0;
      else if (evt.relSeen) relDet <= 1'b1;
      if (cmdClr)           cmdDet <= 1'b0;
      else if (evt.cmdSeen) cmdDet <= 1'b1;
    end
  end

  always_comb begin
    regRdData              = '0;
    regRdData[BIT_ACK_EN]  = ackEn;
    regRdData[BIT_REL_DET] = relDet;
    regRdData[BIT_CMD_DET] = cmdDet;
  end

endmodule

// File: rtl/sbus_ctl_top.sv
module sbus_ctl_top
  import sbus_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int XFER_BITS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              xferStart,
  input  logic              addrCheck,
  input  logic              addrHit,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              soLatch,
  output logic              ackLow,
  output logic              sdaOe
);

  dpCmd_t dpCmd;
  dpEvt_t dpEvt;

  sbus_ctl_regs #(.DATA_W(DATA_W)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .portEn    (portEn),
    .regWr     (regWr),
    .regWrData (regWrData),
    .xferStart (xferStart),
    .addrCheck (addrCheck),
    .addrHit   (addrHit),
    .evt       (dpEvt),
    .cmd       (dpCmd),
    .regRdData (regRdData)
  );

  sbus_ctl_dp #(.SYNC_STAGES(SYNC_STAGES), .XFER_BITS(XFER_BITS)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .portEn  (portEn),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .cmd     (dpCmd),
    .evt     (dpEvt),
    .soLatch (soLatch),
    .ackLow  (ackLow)
  );

  assign sdaOe = ackLow | ~soLatch;

endmodule

// File: rtl/sbus_ctl_chk.sv
module sbus_ctl_chk
  import sbus_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              portEn,
  input logic              regWr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              xferStart,
  input logic              addrCheck,
  input logic              addrHit,
  input logic              soLatch,
  input logic              ackLow
);

  a_r2_rel_trig_sets: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regWrData[BIT_REL_TRIG] |=> soLatch);

  a_r3_cmd_trig_clears: assert property (@(posedge clk) disable iff (!rstN)
    regWr && regWrData[BIT_CMD_TRIG] && !regWrData[BIT_REL_TRIG] |=> !soLatch);

  a_r5_start_clears_flags: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !regRdData[BIT_REL_DET] && !regRdData[BIT_CMD_DET]);

  a_r5_miss_clears_rel: assert property (@(posedge clk) disable iff (!rstN)
    addrCheck && !addrHit |=> !regRdData[BIT_REL_DET]);

  a_r11_disable_quiets: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> !ackLow && !regRdData[BIT_REL_DET] && !regRdData[BIT_CMD_DET]);

  a_r10_trig_bits_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[BIT_ACK_TRIG:BIT_REL_TRIG] == 3'b000 && regRdData[DATA_W-1:BIT_CMD_DET+1] == '0);

endmodule

bind sbus_ctl_top sbus_ctl_chk #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .portEn    (portEn),
  .regWr     (regWr),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .xferStart (xferStart),
  .addrCheck (addrCheck),
  .addrHit   (addrHit),
  .soLatch   (soLatch),
  .ackLow    (ackLow)
);

// File: tb/tb_sbus_ctl_top.sv
`timescale 1ns/1ps
module tb_sbus_ctl_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEn = 1'b1;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       xferStart = 1'b0;
  logic       addrCheck = 1'b0;
  logic       addrHit = 1'b0;
  logic       sclIn = 1'b1;
  logic       sdaIn = 1'b1;
  logic       soLatch, ackLow, sdaOe;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  // bench model
  logic mSo = 1'b1, mRel = 1'b0, mCmd = 1'b0;

  always #5 clk = ~clk;

  sbus_ctl_top dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .regWr(regWr), .regWrData(regWrData),
    .regRdData(regRdData), .xferStart(xferStart), .addrCheck(addrCheck), .addrHit(addrHit),
    .sclIn(sclIn), .sdaIn(sdaIn), .soLatch(soLatch), .ackLow(ackLow), .sdaOe(sdaOe)
  );

  function automatic logic [7:0] expRead(input logic ae, input logic rel, input logic cmd);
    return {2'b00, cmd, rel, ae, 3'b000};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    regWr = 1'b1; regWrData = d; tick(1);
    regWr = 1'b0; regWrData = 8'h00;
  endtask

  task automatic pulseStart();
    xferStart = 1'b1; tick(1); xferStart = 1'b0;
  endtask

  task automatic pulseAddr(input logic hit);
    addrCheck = 1'b1; addrHit = hit; tick(1); addrCheck = 1'b0; addrHit = 1'b0;
  endtask

  task automatic sclSet(input logic v);
    sclIn = v; tick(10);
  endtask

  task automatic sdaSet(input logic v);
    sdaIn = v; tick(6);
  endtask

  task automatic portCycle();
    portEn = 1'b0; tick(2); portEn = 1'b1; tick(1);
  endtask

  task automatic eightClocks();
    for (int i = 0; i < 8; i++) begin sclSet(1'b0); sclSet(1'b1); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    tick(3);
    // R1 reset state
    chk("R1 soLatch", {7'b0, soLatch}, 8'h01);
    chk("R1 ackLow", {7'b0, ackLow}, 8'h00);
    chk("R1 sdaOe", {7'b0, sdaOe}, 8'h00);
    chk("R1 read", regRdData, 8'h00);
    rstN = 1'b1;
    tick(3);

    // constrained random: triggers, line edges, strobes (R2 R3 R4 R5 R6 R10)
    for (int it = 0; it < 120; it++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: begin
          logic [7:0] d;
          d = 8'($urandom) & 8'hF3;
          wr(d);
          if (d[0]) mSo = 1'b1; else if (d[1]) mSo = 1'b0;
        end
        1: begin
          if (sdaIn == 1'b0) begin sdaSet(1'b1); mRel = 1'b1; mCmd = 1'b0; end
          else begin sdaSet(1'b0); mCmd = 1'b1; end
        end
        2: begin sclSet(1'b0); sdaSet(~sdaIn); sclSet(1'b1); end
        3: begin pulseStart(); mRel = 1'b0; mCmd = 1'b0; end
        default: begin
          logic h;
          h = 1'($urandom);
          pulseAddr(h);
          if (!h) mRel = 1'b0;
        end
      endcase
      tick(6);
      chk("R2/R3 random soLatch", {7'b0, soLatch}, {7'b0, mSo});
      chk("R4/R5/R6/R10 random read", regRdData, expRead(1'b0, mRel, mCmd));
    end

    sdaSet(1'b1);
    portCycle();

    // R3 priority and open-drain enable
    wr(8'h02); tick(1);
    chk("R3 cmd trig", {6'b0, soLatch, sdaOe}, 8'h01);
    wr(8'h03); tick(1);
    chk("R3 both bits release wins", {6'b0, soLatch, sdaOe}, 8'h02);
    wr(8'h01); tick(1);
    chk("R2 release trig", {7'b0, soLatch}, 8'h01);

    // R6 command then release in one edge
    sdaSet(1'b0);
    chk("R6 command flag", regRdData, 8'h20);
    sdaSet(1'b1);
    chk("R6 release clears command, R4 sets release", regRdData, 8'h10);
    pulseAddr(1'b1); tick(2);
    chk("R5 address hit keeps flag", regRdData, 8'h10);
    pulseAddr(1'b0); tick(2);
    chk("R5 address miss clears flag", regRdData, 8'h00);
    sdaSet(1'b0); sdaSet(1'b1); sdaSet(1'b0);
    chk("R6 both flags", regRdData, 8'h30);
    portEn = 1'b0; tick(2);
    chk("R5 R6 port disable clears", regRdData, 8'h00);
    portEn = 1'b1; sdaSet(1'b1);
    chk("R4 release after enable", regRdData, 8'h10);
    pulseStart(); tick(2);
    chk("R5 start clears", regRdData, 8'h00);
    portCycle();

    // R7 auto acknowledge, enable written during the transfer
    wr(8'h00);
    pulseStart();
    wr(8'h08);
    eightClocks();
    chk("R7 no ack before 9th fall", {7'b0, ackLow}, 8'h00);
    sclSet(1'b0);
    chk("R7 ack low phase", {6'b0, ackLow, sdaOe}, 8'h03);
    sclSet(1'b1);
    chk("R7 ack high phase", {7'b0, ackLow}, 8'h01);
    sclSet(1'b0);
    chk("R7 ack released", {7'b0, ackLow}, 8'h00);
    sclSet(1'b1);

    // R7/R8 enable write swept around the transfer end
    for (int k = 0; k < 6; k++) begin
      portCycle();
      wr(8'h00);
      pulseStart();
      for (int i = 0; i < 7; i++) begin sclSet(1'b0); sclSet(1'b1); end
      sclSet(1'b0);
      sclIn = 1'b1;
      tick(k);
      wr(8'h08);
      tick(9 - k);
      chk($sformatf("R7 sweep %0d idle before fall", k), {7'b0, ackLow}, 8'h00);
      sclSet(1'b0);
      chk($sformatf("R7 sweep %0d ack", k), {7'b0, ackLow}, 8'h01);
      sclSet(1'b1);
      sclSet(1'b0);
      chk($sformatf("R7 sweep %0d release", k), {7'b0, ackLow}, 8'h00);
      sclSet(1'b1);
      sclSet(1'b0);
      chk($sformatf("R7 sweep %0d single pulse", k), {7'b0, ackLow}, 8'h00);
      sclSet(1'b1);
    end

    // R8 enable written while idle
    portCycle();
    wr(8'h00);
    wr(8'h08); tick(3);
    chk("R8 pending only", {7'b0, ackLow}, 8'h00);
    chk("R10 enable readback", regRdData, 8'h08);
    sclSet(1'b0);
    chk("R8 ack on next clock", {7'b0, ackLow}, 8'h01);
    sclSet(1'b1); sclSet(1'b0);
    chk("R8 released", {7'b0, ackLow}, 8'h00);
    sclSet(1'b1);

    // R9 trigger while idle
    wr(8'h00);
    wr(8'h04); tick(2);
    chk("R9 R10 trigger reads zero", regRdData, 8'h00);
    sclSet(1'b0);
    chk("R9 ack from trigger", {7'b0, ackLow}, 8'h01);
    sclSet(1'b1); sclSet(1'b0);
    chk("R9 released", {7'b0, ackLow}, 8'h00);
    sclSet(1'b1);

    // R9 trigger during transfer ignored
    portCycle();
    pulseStart();
    wr(8'h04);
    eightClocks();
    sclSet(1'b0);
    chk("R9 trigger ignored in transfer", {7'b0, ackLow}, 8'h00);
    sclSet(1'b1); sclSet(1'b0);
    chk("R9 still no ack", {7'b0, ackLow}, 8'h00);
    sclSet(1'b1);

    // R11 port disable aborts acknowledge
    wr(8'h04);
    sclSet(1'b0);
    chk("R11 ack running", {7'b0, ackLow}, 8'h01);
    portEn = 1'b0; tick(2);
    chk("R11 ack aborted", {7'b0, ackLow}, 8'h00);
    portEn = 1'b1;
    sclSet(1'b1); sclSet(1'b0);
    chk("R11 nothing pending", {7'b0, ackLow}, 8'h00);
    sclSet(1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule